// File: doc/BRIEF.md
# Four-Term Weighted-Average Defuzzifier

This block turns the four fired rules of a two-input fuzzy controller into one crisp output value. Each rule supplies a firing strength and a singleton consequent. The block multiplies each strength by its consequent and adds up the four products. It divides that total by the sum of the four strengths. The truncated quotient is delivered as an 8-bit code that a DAC can take directly. All arithmetic is unsigned fixed-point integer.

A sample begins when `start` is pulsed while the block is idle. The operands are captured on that clock edge. One term is accumulated per cycle, so the four terms take four cycles. A restoring divider then produces one quotient bit per cycle. The latency is fixed and does not depend on the data, so a sampling loop can be timed around it.

When every strength is zero, no rule has fired. In that case the output keeps its previous value and a flag marks the sample.

Top module: `fuzzy_wavg_defuzz`

## Requirements
- R1: After reset, `done`, `busy`, `no_rule` and `out_value` are all 0.
- R2: `start` is accepted only when `busy` is low. The operands are captured on the accepting edge, and `busy` is high from the next cycle until the result is delivered. A `start` pulse or an operand change while `busy` is high has no effect on the result or on the timing.
- R3: `done` goes high for exactly one cycle, after the 24th rising edge that follows the accepting edge (four accumulate cycles, one divider load cycle, 18 divider cycles and one result cycle). `done` goes low again on the next edge.
- R4: Term i occupies bits [8i+7:8i] of both `strength_vec` and `conseq_vec`, for i = 0..3. When the total strength is nonzero, `out_value` equals floor(sum of strength_i*consequent_i / sum of strength_i), and it is valid while `done` is high.
- R5: No intermediate value overflows. The numerator is held in 18 bits and the denominator in 10 bits, so all strengths and consequents at 255 give an output of 255. Any quotient above 255 is clamped to 255.
- R6: When all four strengths are zero, `no_rule` is 1 while `done` is high, and `out_value` keeps the value of the previous sample (0 if there has been none).
- R7: `no_rule` holds its value until the next `done`. It returns to 0 on the first later sample whose total strength is nonzero.
- R8: A delivered result is never greater than the largest of the four captured consequents. If only one strength is nonzero, the output equals that term's consequent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sample; honoured only while idle |
| strength_vec | input | 32 | Four 8-bit firing strengths, term i at bits [8i+7:8i] |
| conseq_vec | input | 32 | Four 8-bit singleton consequents, term i at bits [8i+7:8i] |
| busy | output | 1 | High while a sample is being computed |
| done | output | 1 | One-cycle pulse when the result is delivered |
| out_value | output | 8 | Crisp controller output |
| no_rule | output | 1 | Last delivered sample had zero total strength |

## Verification
The bench targets the zero-total-strength sample. A design that divided by zero anyway would put 255 or garbage on the output instead of holding it, and one that forgot to clear the flag would leave `no_rule` stuck high on the sample after. Full-scale operands expose a numerator or denominator that is too narrow: the result wraps to a small value instead of 255. A single nonzero strength, and a set of strengths of one each, check the truncating division and the term ordering exactly. A `start` pulse with fresh operands in the middle of a computation catches a design that restarts or re-latches: the result would come from the wrong operands, or `done` would arrive at a different cycle count.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
   // Sequencer phases of the defuzzifier
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ACC  = 3'd1,
      PH_LOAD = 3'd2,
      PH_DIV  = 3'd3,
      PH_FIN  = 3'd4
   } fwd_phase_e;
endpackage

// File: rtl/fwd_mac.sv
`timescale 1ns/1ps
// Sequential multiply-accumulate: one strength/consequent pair per enabled cycle.
module fwd_mac #(
   parameter int STR_W = 8,
   parameter int CON_W = 8,
   parameter int NUM_W = 18,
   parameter int DEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic [STR_W-1:0] str_in,
   input  logic [CON_W-1:0] con_in,
   output logic [NUM_W-1:0] num,
   output logic [DEN_W-1:0] den
);
   localparam int PROD_W = STR_W + CON_W;

   initial begin
      assert (NUM_W >= PROD_W) else $error("numerator narrower than one product");
      assert (DEN_W >= STR_W) else $error("denominator narrower than one strength");
   end

   logic [PROD_W-1:0] prod;
   assign prod = str_in * con_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num <= '0;
         den <= '0;
      end else if (clear) begin
         num <= '0;
         den <= '0;
      end else if (en) begin
         num <= num + NUM_W'(prod);
         den <= den + DEN_W'(str_in);
      end
   end

   // R5: accumulation never wraps within a sample
   assert_den_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clear) |=> (den >= $past(den) && num >= $past(num)));
endmodule

// File: rtl/fwd_rdiv.sv
`timescale 1ns/1ps
// Restoring divider, one quotient bit per step.
module fwd_rdiv #(
   parameter int NUM_W = 18,
   parameter int DEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [NUM_W-1:0] dividend,
   input  logic [DEN_W-1:0] divisor,
   output logic [NUM_W-1:0] quotient
);
   initial begin
      assert (NUM_W >= 2) else $error("dividend too narrow");
      assert (DEN_W >= 1) else $error("divisor too narrow");
   end

   logic [DEN_W-1:0] rem;
   logic [DEN_W-1:0] dvs;
   logic [NUM_W-1:0] quo;
   logic [DEN_W:0]   shifted;
   logic [DEN_W:0]   diff;
   logic             fits;

   assign shifted  = {rem, quo[NUM_W-1]};
   assign fits     = (shifted >= {1'b0, dvs});
   assign diff     = shifted - {1'b0, dvs};
   assign quotient = quo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem <= '0;
         dvs <= '0;
         quo <= '0;
      end else if (load) begin
         rem <= '0;
         dvs <= divisor;
         quo <= dividend;
      end else if (step) begin
         if (fits) begin
            rem <= diff[DEN_W-1:0];
            quo <= {quo[NUM_W-2:0], 1'b1};
         end else begin
            rem <= shifted[DEN_W-1:0];
            quo <= {quo[NUM_W-2:0], 1'b0};
         end
      end
   end

   // R4: partial remainder stays below the divisor after every step
   assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && dvs != '0) |=> (rem < dvs));
endmodule

// File: rtl/fuzzy_wavg_defuzz.sv
`timescale 1ns/1ps
module fuzzy_wavg_defuzz #(
   parameter int N_TERMS = 4,
   parameter int STR_W   = 8,
   parameter int CON_W   = 8,
   parameter int OUT_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [N_TERMS*STR_W-1:0] strength_vec,
   input  logic [N_TERMS*CON_W-1:0] conseq_vec,
   output logic                     busy,
   output logic                     done,
   output logic [OUT_W-1:0]         out_value,
   output logic                     no_rule
);
   import fwd_pkg::*;

   localparam int IDX_W = $clog2(N_TERMS);
   localparam int NUM_W = STR_W + CON_W + IDX_W;
   localparam int DEN_W = STR_W + IDX_W;
   localparam int SEQ_W = $clog2(NUM_W + N_TERMS) + 1;
   localparam int LAT   = N_TERMS + NUM_W + 2;
   localparam int LAT_W = $clog2(LAT + 2) + 1;

   initial begin
      assert (N_TERMS >= 2) else $error("need at least two terms");
      assert (OUT_W >= 1 && OUT_W <= NUM_W) else $error("bad output width");
   end

   fwd_phase_e           phase;
   logic [SEQ_W-1:0]     cnt;
   logic [N_TERMS*STR_W-1:0] str_lat;
   logic [N_TERMS*CON_W-1:0] con_lat;
   logic [STR_W-1:0]     str_arr [N_TERMS];
   logic [CON_W-1:0]     con_arr [N_TERMS];
   logic [NUM_W-1:0]     num;
   logic [DEN_W-1:0]     den;
   logic [NUM_W-1:0]     quo;
   logic [OUT_W-1:0]     narrowed;
   logic                 zero_den;
   logic                 accept;

   assign accept = start && (phase == PH_IDLE);
   assign busy   = (phase != PH_IDLE);

   // unpack the captured operands
   for (genvar g = 0; g < N_TERMS; g++) begin : g_unpack
      assign str_arr[g] = str_lat[g*STR_W +: STR_W];
      assign con_arr[g] = con_lat[g*CON_W +: CON_W];
   end

   fwd_mac #(.STR_W(STR_W), .CON_W(CON_W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .en     (phase == PH_ACC),
      .str_in (str_arr[cnt[IDX_W-1:0]]),
      .con_in (con_arr[cnt[IDX_W-1:0]]),
      .num    (num),
      .den    (den)
   );

   fwd_rdiv #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (phase == PH_LOAD),
      .step     (phase == PH_DIV),
      .dividend (num),
      .divisor  (den),
      .quotient (quo)
   );

   // output narrowing: clamp when the quotient is wider than the output
   if (NUM_W > OUT_W) begin : g_clamp
      assign narrowed = (|quo[NUM_W-1:OUT_W]) ? {OUT_W{1'b1}} : quo[OUT_W-1:0];
   end else begin : g_direct
      assign narrowed = quo[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         str_lat   <= '0;
         con_lat   <= '0;
         zero_den  <= 1'b0;
         done      <= 1'b0;
         no_rule   <= 1'b0;
         out_value <= '0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: if (start) begin
               str_lat <= strength_vec;
               con_lat <= conseq_vec;
               cnt     <= '0;
               phase   <= PH_ACC;
            end
            PH_ACC: begin
               if (cnt == SEQ_W'(N_TERMS - 1)) begin
                  cnt   <= '0;
                  phase <= PH_LOAD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_LOAD: begin
               zero_den <= (den == '0);
               cnt      <= '0;
               phase    <= PH_DIV;
            end
            PH_DIV: begin
               if (cnt == SEQ_W'(NUM_W - 1)) begin
                  cnt   <= '0;
                  phase <= PH_FIN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_FIN: begin
               done    <= 1'b1;
               no_rule <= zero_den;
               if (!zero_den) out_value <= narrowed;
               phase   <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // ---------------- checker logic ----------------
   logic [LAT_W-1:0] lat_cnt;
   logic [CON_W-1:0] con_max;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_cnt <= '0;
      else if (accept) lat_cnt <= '0;
      else if (busy)   lat_cnt <= lat_cnt + 1'b1;
   end

   always_comb begin
      con_max = '0;
      for (int i = 0; i < N_TERMS; i++)
         if (con_arr[i] > con_max) con_max = con_arr[i];
   end

   assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == LAT_W'(LAT)));
   assert_hold_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && no_rule) |-> $stable(out_value));
   assert_upper_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !no_rule) |-> ({{(NUM_W-OUT_W){1'b0}}, out_value} <= NUM_W'(con_max)));
endmodule

// File: tb/fuzzy_wavg_defuzz_test.sv
`timescale 1ns/1ps
module fuzzy_wavg_defuzz_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] strength_vec = '0;
   logic [31:0] conseq_vec = '0;
   logic        busy, done, no_rule;
   logic [7:0]  out_value;

   int checks = 0;
   int failures = 0;
   int prev_exp = 0;

   always #5 clk = ~clk;

   fuzzy_wavg_defuzz uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .strength_vec(strength_vec), .conseq_vec(conseq_vec),
      .busy(busy), .done(done), .out_value(out_value), .no_rule(no_rule)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ref_num(input logic [31:0] s, input logic [31:0] c);
      int acc = 0;
      for (int i = 0; i < 4; i++) acc += int'(s[i*8 +: 8]) * int'(c[i*8 +: 8]);
      return acc;
   endfunction

   function automatic int ref_den(input logic [31:0] s);
      int acc = 0;
      for (int i = 0; i < 4; i++) acc += int'(s[i*8 +: 8]);
      return acc;
   endfunction

   // run one sample; optionally disturb inputs and pulse start mid-computation
   task automatic run_sample(input logic [31:0] sv, input logic [31:0] cv, input bit disturb,
                             input string tag);
      int lat, n, d, exp_out, exp_nr;
      n = ref_num(sv, cv);
      d = ref_den(sv);
      if (d == 0) begin
         exp_out = prev_exp; exp_nr = 1;
      end else begin
         exp_out = n / d; if (exp_out > 255) exp_out = 255; exp_nr = 0;
      end
      @(negedge clk);
      strength_vec = sv; conseq_vec = cv; start = 1'b1;
      @(posedge clk); #1;
      check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      lat = 0;
      while (1) begin
         @(negedge clk);
         start = disturb && (lat == 5);
         if (disturb) begin
            strength_vec = $urandom; conseq_vec = $urandom;
         end
         @(posedge clk);
         lat++;
         #1;
         if (done || lat > 60) break;
      end
      check(lat == 24, {"R3 latency ", tag}, lat, 24);
      check(int'(out_value) == exp_out, {"R4 output ", tag}, int'(out_value), exp_out);
      check(int'(no_rule) == exp_nr, {"R6/R7 no_rule ", tag}, int'(no_rule), exp_nr);
      @(negedge clk); start = 1'b0;
      @(posedge clk); #1;
      check(done == 1'b0, {"R3 done single cycle ", tag}, int'(done), 0);
      check(int'(no_rule) == exp_nr, {"R7 no_rule held ", tag}, int'(no_rule), exp_nr);
      prev_exp = exp_out;
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int dummy;
      dummy = $urandom(32'd20240611);
      #23;
      check(done == 1'b0 && busy == 1'b0, "R1 reset done/busy", int'({done, busy}), 0);
      check(out_value == 8'd0 && no_rule == 1'b0, "R1 reset out/no_rule",
            int'({no_rule, out_value}), 0);
      rst_n = 1'b1;

      // R6: zero strength before any sample holds the reset value 0
      run_sample(32'h0000_0000, 32'hAABB_CCDD, 1'b0, "zero first");
      // R5: full scale operands
      run_sample(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "full scale");
      // R8: single fired term gives its consequent exactly
      run_sample(32'h00C8_0000, 32'h114D_2233, 1'b0, "single term");
      check(out_value == 8'd77, "R8 single term value", int'(out_value), 77);
      // R4: truncation, weights of one: (1+2+3+4)/4 = 2
      run_sample(32'h0101_0101, 32'h0403_0201, 1'b0, "unit weights");
      // R6: zero strength holds previous value
      run_sample(32'h0000_0000, 32'hFFFF_FFFF, 1'b0, "zero hold");
      check(out_value == 8'd2, "R6 held value", int'(out_value), 2);
      // R7: next nonzero sample clears the flag
      run_sample(32'h0080_0040, 32'h00F0_0010, 1'b0, "recover");
      // R2: start and operand changes during busy are ignored
      run_sample(32'h1020_3040, 32'h0A14_1E28, 1'b1, "disturbed");
      // R4: random operands, some strengths masked to zero
      for (int k = 0; k < 40; k++) begin
         logic [31:0] sv, cv;
         sv = $urandom; cv = $urandom;
         for (int t = 0; t < 4; t++) if (($urandom % 3) == 0) sv[t*8 +: 8] = 8'd0;
         if ((k % 13) == 7) sv = 32'd0;
         run_sample(sv, cv, (k % 9) == 4, "random");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule